// File: doc/BRIEF.md
# Pipelined 32x32 Long Multiply-Accumulate Unit

This unit forms the full 64-bit product of two 32-bit operands and can add a 64-bit accumulator to that product. A per-item mode input selects whether the operands are read as unsigned integers or as two's-complement integers. A second per-item input selects whether the 64-bit value on the high and low accumulator words is added to the product. The result leaves the unit as separate high and low 32-bit words, with a valid strobe.

The datapath has two pipeline stages and does not stall. Each input item is flagged by a valid strobe, and a new item may be presented on every clock. The result of an item presented in cycle n is on the outputs in cycle n+2. The unit produces no flags. Sum overflow is discarded silently.

Top module: `wide_mac`

## Requirements
- R1: With `is_signed`=0 and `acc_en`=0, {`res_hi`,`res_lo`} is the unsigned 64-bit product of `op_a` and `op_b`. `res_lo` holds product bits 31..0 and `res_hi` holds bits 63..32.
- R2: With `is_signed`=1 and `acc_en`=0, {`res_hi`,`res_lo`} is the two's-complement 64-bit product of `op_a` and `op_b`, each read as a signed 32-bit integer.
- R3: With `acc_en`=1, the result is the product (signed or unsigned, as R1/R2) plus the 64-bit value {`acc_hi`,`acc_lo`}, where `acc_hi` is bits 63..32. In signed mode that value is signed, and in unsigned mode it is unsigned.
- R4: An accumulate sum that exceeds 64 bits wraps modulo 2^64. No overflow or other flag exists.
- R5: With `acc_en`=0, the values on `acc_hi` and `acc_lo` have no effect on the result.
- R6: When `in_valid` is high in cycle n, `out_valid` is high in cycle n+2 with that item's result. `out_valid` is never high otherwise. Items are accepted on every cycle with no busy signal.
- R7: `rst` is synchronous and active-high. One clock after `rst` is sampled high, `out_valid` is low. Items still in flight are discarded.
- R8: `is_signed` and `acc_en` are sampled with each item. Items in adjacent cycles may use different modes, and each result follows its own item's mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input item strobe |
| op_a | input | 32 | First multiplicand |
| op_b | input | 32 | Second multiplicand |
| acc_hi | input | 32 | Accumulator bits 63..32 |
| acc_lo | input | 32 | Accumulator bits 31..0 |
| is_signed | input | 1 | 1: two's-complement operands, 0: unsigned |
| acc_en | input | 1 | 1: add accumulator to product |
| out_valid | output | 1 | Result strobe, two cycles after in_valid |
| res_hi | output | 32 | Result bits 63..32 |
| res_lo | output | 32 | Result bits 31..0 |

## Verification
The bench targets operands with the top bit set, such as all-ones times all-ones and the most negative value squared. If the signed correction is missing or applied in the wrong mode, these results differ in the high word. Accumulates that carry out of bit 63 detect a datapath that saturates or keeps an extra bit. All-ones values on the accumulator inputs with accumulate disabled detect a design that does not mask them. Back-to-back items that alternate modes, and a reset asserted while items are in flight, detect mode bits that skew against their data and valid strobes that leak through reset or arrive a cycle early or late.

// File: rtl/lmac_pkg.sv
package lmac_pkg;

   typedef enum logic {
      LMAC_UNSIGNED = 1'b0,
      LMAC_SIGNED   = 1'b1
   } lmac_kind_e;

   function automatic int unsigned lmac_slices(input int unsigned width,
                                               input int unsigned slice);
      return width / slice;
   endfunction

   function automatic int unsigned lmac_pp_shift(input int unsigned idx,
                                                 input int unsigned nsl,
                                                 input int unsigned slice);
      return ((idx / nsl) + (idx % nsl)) * slice;
   endfunction

endpackage

// File: rtl/lmac_slice_mul.sv
module lmac_slice_mul #(
   parameter int unsigned SLICE_W = 16,
   localparam int unsigned P_W = 2 * SLICE_W
) (
   input  logic [SLICE_W-1:0] slice_a,
   input  logic [SLICE_W-1:0] slice_b,
   output logic [P_W-1:0]     slice_p
);
   // Unsigned slice product. Sign handling is done once for the whole
   // operand by a correction term in the partial-product stage.
   always_comb begin
      slice_p = P_W'(slice_a) * P_W'(slice_b);
   end
endmodule

// File: rtl/lmac_pp_stage.sv
module lmac_pp_stage
   import lmac_pkg::*;
#(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned SLICE_W = 16,
   localparam int unsigned NSL    = lmac_slices(DATA_W, SLICE_W),
   localparam int unsigned NPP    = NSL * NSL,
   localparam int unsigned PP_W   = 2 * SLICE_W,
   localparam int unsigned ACC_W  = 2 * DATA_W
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      in_valid,
   input  logic [DATA_W-1:0]         op_a,
   input  logic [DATA_W-1:0]         op_b,
   input  logic [DATA_W-1:0]         acc_hi,
   input  logic [DATA_W-1:0]         acc_lo,
   input  lmac_kind_e                kind,
   input  logic                      acc_en,
   output logic                      s1_valid,
   output logic [NPP-1:0][PP_W-1:0]  s1_pp,
   output logic [DATA_W-1:0]         s1_corr,
   output logic [ACC_W-1:0]          s1_acc
);

   logic [NPP-1:0][PP_W-1:0] pp_d;
   logic [DATA_W-1:0]        corr_d;
   logic [ACC_W-1:0]         acc_d;
   logic                     neg_a;
   logic                     neg_b;

   // Partial products: one unsigned slice multiplier per (i,j) slice pair.
   for (genvar i = 0; i < NSL; i++) begin : g_row
      for (genvar j = 0; j < NSL; j++) begin : g_col
         lmac_slice_mul #(
            .SLICE_W (SLICE_W)
         ) u_mul (
            .slice_a (op_a[i*SLICE_W +: SLICE_W]),
            .slice_b (op_b[j*SLICE_W +: SLICE_W]),
            .slice_p (pp_d[i*NSL + j])
         );
      end
   end

   // Two's-complement correction. Reading a negative operand as unsigned
   // adds 2^W times the other operand. Only the upper result word is
   // affected, so a W-bit term is enough.
   always_comb begin
      neg_a  = (kind == LMAC_SIGNED) && op_a[DATA_W-1];
      neg_b  = (kind == LMAC_SIGNED) && op_b[DATA_W-1];
      corr_d = (neg_a ? op_b : '0) + (neg_b ? op_a : '0);
   end

   // Disabled accumulate is forced to zero here, so stage 2 always adds.
   always_comb begin
      acc_d = acc_en ? {acc_hi, acc_lo} : '0;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         s1_valid <= 1'b0;
      end else begin
         s1_valid <= in_valid;
      end
   end

   // Data registers load only with an item; no reset needed.
   always_ff @(posedge clk) begin
      if (in_valid) begin
         s1_pp   <= pp_d;
         s1_corr <= corr_d;
         s1_acc  <= acc_d;
      end
   end

endmodule

// File: rtl/lmac_sum_stage.sv
module lmac_sum_stage
   import lmac_pkg::*;
#(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned SLICE_W = 16,
   localparam int unsigned NSL    = lmac_slices(DATA_W, SLICE_W),
   localparam int unsigned NPP    = NSL * NSL,
   localparam int unsigned PP_W   = 2 * SLICE_W,
   localparam int unsigned ACC_W  = 2 * DATA_W
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      s1_valid,
   input  logic [NPP-1:0][PP_W-1:0]  s1_pp,
   input  logic [DATA_W-1:0]         s1_corr,
   input  logic [ACC_W-1:0]          s1_acc,
   output logic                      out_valid,
   output logic [DATA_W-1:0]         res_hi,
   output logic [DATA_W-1:0]         res_lo
);

   logic [ACC_W-1:0] prod_u;
   logic [ACC_W-1:0] total;

   if (NSL == 1) begin : g_single
      // One slice spans the operand: the partial product is the product.
      always_comb begin
         prod_u = ACC_W'(s1_pp[0]);
      end
   end else begin : g_tree
      always_comb begin
         prod_u = '0;
         for (int k = 0; k < NPP; k++) begin
            prod_u = prod_u + (ACC_W'(s1_pp[k]) << lmac_pp_shift(k, NSL, SLICE_W));
         end
      end
   end

   // Subtract the sign correction from the upper word, then add the
   // accumulator; any carry beyond ACC_W bits is dropped.
   always_comb begin
      total = prod_u - {s1_corr, {DATA_W{1'b0}}} + s1_acc;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
      end else begin
         out_valid <= s1_valid;
      end
   end

   always_ff @(posedge clk) begin
      if (s1_valid) begin
         res_hi <= total[ACC_W-1:DATA_W];
         res_lo <= total[DATA_W-1:0];
      end
   end

endmodule

// File: rtl/wide_mac.sv
module wide_mac
   import lmac_pkg::*;
#(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned SLICE_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   input  logic [DATA_W-1:0] acc_hi,
   input  logic [DATA_W-1:0] acc_lo,
   input  logic              is_signed,
   input  logic              acc_en,
   output logic              out_valid,
   output logic [DATA_W-1:0] res_hi,
   output logic [DATA_W-1:0] res_lo
);

   localparam int unsigned NSL   = lmac_slices(DATA_W, SLICE_W);
   localparam int unsigned NPP   = NSL * NSL;
   localparam int unsigned PP_W  = 2 * SLICE_W;
   localparam int unsigned ACC_W = 2 * DATA_W;

   if (SLICE_W == 0 || SLICE_W > DATA_W) begin : g_bad_slice
      $error("wide_mac: SLICE_W must be in 1..DATA_W");
   end
   if ((DATA_W % SLICE_W) != 0) begin : g_bad_div
      $error("wide_mac: DATA_W must be a multiple of SLICE_W");
   end
   if (NPP > 64) begin : g_bad_count
      $error("wide_mac: too many partial products");
   end

   lmac_kind_e               kind;
   logic                     s1_valid;
   logic [NPP-1:0][PP_W-1:0] s1_pp;
   logic [DATA_W-1:0]        s1_corr;
   logic [ACC_W-1:0]         s1_acc;

   always_comb begin
      kind = is_signed ? LMAC_SIGNED : LMAC_UNSIGNED;
   end

   lmac_pp_stage #(
      .DATA_W  (DATA_W),
      .SLICE_W (SLICE_W)
   ) u_pp (
      .clk      (clk),
      .rst      (rst),
      .in_valid (in_valid),
      .op_a     (op_a),
      .op_b     (op_b),
      .acc_hi   (acc_hi),
      .acc_lo   (acc_lo),
      .kind     (kind),
      .acc_en   (acc_en),
      .s1_valid (s1_valid),
      .s1_pp    (s1_pp),
      .s1_corr  (s1_corr),
      .s1_acc   (s1_acc)
   );

   lmac_sum_stage #(
      .DATA_W  (DATA_W),
      .SLICE_W (SLICE_W)
   ) u_sum (
      .clk       (clk),
      .rst       (rst),
      .s1_valid  (s1_valid),
      .s1_pp     (s1_pp),
      .s1_corr   (s1_corr),
      .s1_acc    (s1_acc),
      .out_valid (out_valid),
      .res_hi    (res_hi),
      .res_lo    (res_lo)
   );

endmodule

// File: rtl/lmac_checker.sv
module lmac_checker #(
   parameter int unsigned DATA_W = 32,
   localparam int unsigned ACC_W = 2 * DATA_W
) (
   input logic              clk,
   input logic              rst,
   input logic              in_valid,
   input logic [DATA_W-1:0] op_a,
   input logic [DATA_W-1:0] op_b,
   input logic [DATA_W-1:0] acc_hi,
   input logic [DATA_W-1:0] acc_lo,
   input logic              is_signed,
   input logic              acc_en,
   input logic              out_valid,
   input logic [DATA_W-1:0] res_hi,
   input logic [DATA_W-1:0] res_lo
);

   logic [1:0]        since_rst;
   logic              v1, v2;
   logic [DATA_W-1:0] a1, a2, b1, b2;
   logic [ACC_W-1:0]  c1, c2;
   logic              s1, s2, e1, e2;
   logic [ACC_W-1:0]  ref_u, ref_s;

   always_ff @(posedge clk) begin
      if (rst) begin
         since_rst <= '0;
      end else if (since_rst != 2'd3) begin
         since_rst <= since_rst + 2'd1;
      end
   end

   always_ff @(posedge clk) begin
      v1 <= in_valid; v2 <= v1;
      a1 <= op_a;     a2 <= a1;
      b1 <= op_b;     b2 <= b1;
      c1 <= {acc_hi, acc_lo}; c2 <= c1;
      s1 <= is_signed; s2 <= s1;
      e1 <= acc_en;    e2 <= e1;
   end

   always_comb begin
      ref_u = ACC_W'(a2) * ACC_W'(b2);
      ref_s = {{DATA_W{a2[DATA_W-1]}}, a2} * {{DATA_W{b2[DATA_W-1]}}, b2};
   end

   // R6: strobe follows in_valid by exactly two clocks
   a_r6_latency: assert property (@(posedge clk) disable iff (rst)
      (since_rst >= 2'd2) |-> (out_valid == v2));

   // R1 / R5: unsigned product without accumulate
   a_r1_unsigned_product: assert property (@(posedge clk) disable iff (rst)
      (since_rst >= 2'd2 && out_valid && !s2 && !e2) |-> ({res_hi, res_lo} == ref_u));

   // R2: signed product without accumulate
   a_r2_signed_product: assert property (@(posedge clk) disable iff (rst)
      (since_rst >= 2'd2 && out_valid && s2 && !e2) |-> ({res_hi, res_lo} == ref_s));

   // R3 / R4: accumulate, modulo 2^64
   a_r3_accumulate: assert property (@(posedge clk) disable iff (rst)
      (since_rst >= 2'd2 && out_valid && e2) |->
      ({res_hi, res_lo} == ((s2 ? ref_s : ref_u) + c2)));

   // R7: reset empties the pipeline
   a_r7_reset_clears: assert property (@(posedge clk)
      rst |=> !out_valid);

endmodule

bind wide_mac lmac_checker #(.DATA_W(DATA_W)) u_lmac_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .op_a      (op_a),
   .op_b      (op_b),
   .acc_hi    (acc_hi),
   .acc_lo    (acc_lo),
   .is_signed (is_signed),
   .acc_en    (acc_en),
   .out_valid (out_valid),
   .res_hi    (res_hi),
   .res_lo    (res_lo)
);

// File: tb/tb_wide_mac.sv
`timescale 1ns/1ps
module tb_wide_mac;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [31:0] op_a = '0, op_b = '0, acc_hi = '0, acc_lo = '0;
   logic        is_signed = 1'b0, acc_en = 1'b0;
   logic        out_valid;
   logic [31:0] res_hi, res_lo;

   int tests = 0;
   int fails = 0;
   int cycle = 0;

   logic [63:0] exp_q[$];
   int          cyc_q[$];
   string       tag_q[$];

   always #5 clk = ~clk;
   always @(posedge clk) cycle <= cycle + 1;

   wide_mac dut (
      .clk(clk), .rst(rst), .in_valid(in_valid),
      .op_a(op_a), .op_b(op_b), .acc_hi(acc_hi), .acc_lo(acc_lo),
      .is_signed(is_signed), .acc_en(acc_en),
      .out_valid(out_valid), .res_hi(res_hi), .res_lo(res_lo)
   );

   function automatic logic [63:0] model(input logic [31:0] a, input logic [31:0] b,
                                         input logic [31:0] hi, input logic [31:0] lo,
                                         input logic sg, input logic ac);
      logic [63:0] p;
      if (sg) p = {{32{a[31]}}, a} * {{32{b[31]}}, b};
      else    p = {32'h0, a} * {32'h0, b};
      if (ac) p = p + {hi, lo};
      return p;
   endfunction

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic drive(input string tag, input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] hi, input logic [31:0] lo,
                        input logic sg, input logic ac);
      @(negedge clk);
      in_valid = 1'b1; op_a = a; op_b = b; acc_hi = hi; acc_lo = lo;
      is_signed = sg; acc_en = ac;
      exp_q.push_back(model(a, b, hi, lo, sg, ac));
      cyc_q.push_back(cycle);
      tag_q.push_back(tag);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
         op_a = $urandom; op_b = $urandom; acc_hi = $urandom; acc_lo = $urandom;
      end
   endtask

   // Monitor / scoreboard
   always @(negedge clk) begin
      if (!rst && out_valid) begin
         if (exp_q.size() == 0) begin
            check("R6 unexpected out_valid", 64'd1, 64'd0);
         end else begin
            logic [63:0] e;
            int          c;
            string       t;
            e = exp_q.pop_front();
            c = cyc_q.pop_front();
            t = tag_q.pop_front();
            check(t, {res_hi, res_lo}, e);
            check("R6 latency", 64'(cycle - c), 64'd2);
         end
      end
   end

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      fails++;
      tests++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      check("R7 out_valid low during reset", 64'(out_valid), 64'd0);
      @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check("R7 out_valid low after reset", 64'(out_valid), 64'd0);

      // R1 unsigned
      drive("R1 max*max", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0, 0);
      drive("R1 mixed", 32'h1234_5678, 32'h9ABC_DEF0, 0, 0, 0, 0);
      drive("R1 zero", 32'h0, 32'hDEAD_BEEF, 0, 0, 0, 0);
      // R2 signed
      drive("R2 -1*-1", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 1, 0);
      drive("R2 min*min", 32'h8000_0000, 32'h8000_0000, 0, 0, 1, 0);
      drive("R2 min*1", 32'h8000_0000, 32'h1, 0, 0, 1, 0);
      drive("R2 neg*pos", 32'hFFFF_FFF9, 32'h0000_0003, 0, 0, 1, 0);
      // R3 accumulate
      drive("R3 unsigned acc", 32'h0001_0000, 32'h0001_0000, 32'h0000_0001, 32'hFFFF_FFFF, 0, 1);
      drive("R3 signed acc", 32'hFFFF_FFFF, 32'h0000_0005, 32'h0000_0000, 32'h0000_0003, 1, 1);
      drive("R3 signed negacc", 32'h2, 32'h3, 32'hFFFF_FFFF, 32'hFFFF_FFF0, 1, 1);
      // R4 wrap
      drive("R4 unsigned wrap", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 1);
      drive("R4 signed wrap", 32'h8000_0000, 32'h8000_0000, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1, 1);
      // R5 accumulator ignored
      drive("R5 acc ignored unsigned", 32'h0000_0007, 32'h0000_0009, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0);
      drive("R5 acc ignored signed", 32'hFFFF_FFFE, 32'h0000_0004, 32'hA5A5_A5A5, 32'h5A5A_5A5A, 1, 0);
      idle(4);

      // R8 alternating modes back-to-back
      for (int i = 0; i < 8; i++) begin
         drive("R8 alternating modes", 32'hF000_0001 + i, 32'h8765_4321 - i,
               32'h1111_2222, 32'h3333_4444, i[0], i[1]);
      end
      idle(4);

      // R6 gaps between items
      drive("R6 gap item a", 32'h0000_0100, 32'h0000_0100, 0, 0, 0, 0);
      idle(1);
      drive("R6 gap item b", 32'h8000_0001, 32'h7FFF_FFFF, 0, 0, 1, 0);
      idle(3);
      drive("R6 gap item c", 32'h0000_0003, 32'hFFFF_FFFD, 0, 5, 1, 1);
      idle(4);

      // R7 reset while items in flight
      drive("R7 flushed", 32'h1, 32'h1, 0, 0, 0, 0);
      @(negedge clk);
      rst = 1'b1; in_valid = 1'b0;
      exp_q.delete(); cyc_q.delete(); tag_q.delete();
      @(negedge clk);
      check("R7 in-flight item dropped", 64'(out_valid), 64'd0);
      @(negedge clk);
      check("R7 out_valid held low", 64'(out_valid), 64'd0);
      rst = 1'b0;
      idle(3);

      // Random back-to-back traffic, all modes (R1, R2, R3)
      for (int i = 0; i < 300; i++) begin
         drive("R1/R2/R3 random", $urandom, $urandom, $urandom, $urandom,
               1'($urandom), 1'($urandom));
      end
      idle(5);

      check("R6 no item lost", 64'(exp_q.size()), 64'd0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule